// File: doc/BRIEF.md
# Weighted Round-Robin Queue Scheduler with Strict-Priority Prefix

This block picks which of up to eight command queues belonging to one output port may send next. A prefix of queues can be marked strict-priority. Any such queue that holds data wins ahead of everything else, and the lowest index wins among them. All other attached queues share the port through an eight-round weighted round-robin. Each queue's weight, from 0 to 8, becomes an 8-bit round mask. Bit r of that mask lets the queue take part in round r, and the set bits are spaced out so that one queue's traffic does not arrive in clumps.

Software fills a shadow table of per-queue codes through a write port. It then commits the table together with the number of attached queues. A two-state controller (CFG_IDLE, CFG_CHECK) validates the shadow table before copying it into the active table. A commit moves CFG_IDLE to CFG_CHECK. CFG_CHECK always returns to CFG_IDLE: it either applies the table or raises the error flag and keeps the old table.

Each cycle, the decision logic resolves to one of four named outcomes. PICK_STATIC serves a strict queue. PICK_SAME serves a queue still waiting in the current round. PICK_NEXT moves on to the next round that has work and serves a queue there. PICK_NONE means nothing is eligible. The grant is combinational and is qualified by `out_ready`.

Top module: `wrr_sched`

## Requirements
- R1: After reset no queue is attached, `gnt_vld` stays 0 whatever the inputs, and `cfg_err` is 0.
- R2: Weight codes 0 to 8 select round masks 0x00, 0x01, 0x11, 0x49, 0x55, 0x57, 0x77, 0x7F and 0xFF, where bit r enables round r. Over one full cycle of rounds, a queue of weight w is therefore served w times.
- R3: Code 9 marks a queue as strict-priority. When any attached strict queue is non-empty, the lowest such index is granted and `gnt_static` is 1.
- R4: Within a round, each eligible queue (attached, non-strict, non-empty, mask bit set) is granted at most once. The search starts at the index after the last weighted grant and wraps around.
- R5: When no queue remains in the current round, the scheduler moves to the first later round, wrapping and finally counting the current round afresh, that has an eligible queue. It grants there in the same cycle. `gnt_round` shows the round served. No grant is withheld while any eligible queue exists.
- R6: With `out_ready` at 0, `gnt_vld` is 0 and the scheduling state does not change.
- R7: `gnt_oh` is one-hot at bit `gnt_idx` when `gnt_vld` is 1 and zero otherwise. `gnt_tail` is 1 exactly when the granted index equals the attached count minus one.
- R8: A commit is rejected, and `cfg_err` set to 1, in three cases: the attached count is 0 or above 8, an attached queue holds a code above 9, or the strict queues do not form a run starting at queue 0. A rejected commit leaves the previous active table in use. An accepted commit clears `cfg_err`.
- R9: `cfg_commit` is sampled in CFG_IDLE, and the new table takes effect after the second rising edge. Applying the table restarts the scheduler at round 0 with no queue yet served in that round and the search pointer at the last index.
- R10: Queues at or above the attached count are never granted, and their shadow codes are not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one shadow code |
| cfg_qsel | input | 3 | Queue index of the shadow write |
| cfg_code | input | 4 | Code: 0..8 weight, 9 strict |
| cfg_commit | input | 1 | Validate and apply the shadow table |
| cfg_count | input | 4 | Attached queue count sampled with the commit |
| cfg_err | output | 1 | Last commit was rejected |
| q_nonempty | input | 8 | Per-queue data-present flags |
| out_ready | input | 1 | Downstream can take a grant this cycle |
| gnt_vld | output | 1 | A queue is granted this cycle |
| gnt_oh | output | 8 | One-hot grant vector |
| gnt_idx | output | 3 | Granted queue index |
| gnt_static | output | 1 | Grant went to a strict queue |
| gnt_tail | output | 1 | Granted queue is the last attached queue |
| gnt_round | output | 3 | Round in which the grant falls |

## Verification
Two queues with a full-weight partner are swept over every weight code, with all queues permanently non-empty. The exact bit spacing of each mask shows up as a distinct grant order, and the grant count per cycle of rounds confirms the weight. The strict prefix length is swept from zero to three under pseudo-random occupancy and readiness. This separates strict preemption from round-robin order, and it exercises sparse occupancy, which forces rounds to be skipped. Rejected commits are followed by traffic, so that a table swapped in by mistake would change the grant sequence. A code left in an unattached slot distinguishes the attached-count check from a check of the whole table.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    localparam int ROUNDS  = 8;
    localparam int ROUND_W = $clog2(ROUNDS);
    localparam int CODE_W  = 4;
    localparam logic [CODE_W-1:0] CODE_STRICT = 4'd9;

    typedef logic [ROUNDS-1:0] rmask_t;

    typedef enum logic {
        CFG_IDLE,
        CFG_CHECK
    } cfg_state_e;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_STATIC,
        PICK_SAME,
        PICK_NEXT
    } pick_e;

    // Round-enable pattern per weight; bits spaced to avoid clumping.
    function automatic rmask_t weight_mask(input logic [CODE_W-1:0] code);
        rmask_t m;
        case (code)
            4'd0:    m = 8'h00;
            4'd1:    m = 8'h01;
            4'd2:    m = 8'h11;
            4'd3:    m = 8'h49;
            4'd4:    m = 8'h55;
            4'd5:    m = 8'h57;
            4'd6:    m = 8'h77;
            4'd7:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wrr_cfg_table.sv
module wrr_cfg_table
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = $clog2(NQ),
    parameter int CW = $clog2(NQ + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [QW-1:0]                 wr_idx,
    input  logic [CODE_W-1:0]             wr_code,
    input  logic                          commit,
    input  logic [CW-1:0]                 commit_cnt,
    output logic [NQ-1:0][ROUNDS-1:0]     act_mask,
    output logic [NQ-1:0]                 act_static,
    output logic [NQ-1:0]                 act_attached,
    output logic [CW-1:0]                 act_cnt,
    output logic                          cfg_err,
    output logic                          apply
);

    cfg_state_e                 state_q, state_d;
    logic [NQ-1:0][CODE_W-1:0]  shadow_code;
    logic [CW-1:0]              pend_cnt;

    logic [NQ-1:0]              att_c;
    logic [NQ-1:0]              stat_c;
    logic [NQ-1:0][ROUNDS-1:0]  msk_c;
    logic                       bad_code_c;
    logic                       prefix_ok_c;
    logic                       cnt_ok_c;
    logic                       valid_c;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE:  if (commit) state_d = CFG_CHECK;
            CFG_CHECK: state_d = CFG_IDLE;
        endcase
    end

    // Shadow table and pending count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_code <= '0;
            pend_cnt    <= '0;
        end else begin
            if (wr_en) shadow_code[wr_idx] <= wr_code;
            if (state_q == CFG_IDLE && commit) pend_cnt <= commit_cnt;
        end
    end

    // Validation of the shadow table against the pending count
    always_comb begin
        bad_code_c = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            att_c[q]  = (CW'(q) < pend_cnt);
            stat_c[q] = att_c[q] && (shadow_code[q] == CODE_STRICT);
            msk_c[q]  = att_c[q] ? weight_mask(shadow_code[q]) : '0;
            if (att_c[q] && (shadow_code[q] > CODE_STRICT)) bad_code_c = 1'b1;
        end
        prefix_ok_c = ((stat_c & (stat_c + NQ'(1))) == '0);
        cnt_ok_c    = (pend_cnt != '0) && (pend_cnt <= CW'(NQ));
        valid_c     = !bad_code_c && prefix_ok_c && cnt_ok_c;
    end

    assign apply = (state_q == CFG_CHECK) && valid_c;

    // Active table and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mask     <= '0;
            act_static   <= '0;
            act_attached <= '0;
            act_cnt      <= '0;
            cfg_err      <= 1'b0;
        end else if (state_q == CFG_CHECK) begin
            if (valid_c) begin
                act_mask     <= msk_c;
                act_static   <= stat_c;
                act_attached <= att_c;
                act_cnt      <= pend_cnt;
                cfg_err      <= 1'b0;
            end else begin
                cfg_err      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrr_round_pick.sv
module wrr_round_pick
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = $clog2(NQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      take,
    input  logic [NQ-1:0]             nonempty,
    input  logic [NQ-1:0][ROUNDS-1:0] act_mask,
    input  logic [NQ-1:0]             act_static,
    input  logic [NQ-1:0]             act_attached,
    output logic                      gnt_vld,
    output logic [QW-1:0]             gnt_idx,
    output logic [ROUND_W-1:0]        round_sel,
    output pick_e                     kind
);

    logic [ROUND_W-1:0]           round_q;
    logic [NQ-1:0]                served_q;
    logic [QW-1:0]                last_q;

    logic [NQ-1:0]                stat_req;
    logic [ROUNDS-1:0][NQ-1:0]    elig;
    logic [NQ-1:0]                remain;
    logic                         nr_found;
    logic [ROUND_W-1:0]           nr_round;
    logic [ROUND_W-1:0]           rr;
    logic [QW-1:0]                stat_idx;

    // First set bit strictly after 'from', wrapping.
    function automatic logic [QW-1:0] first_after(input logic [NQ-1:0] v,
                                                  input logic [QW-1:0] from);
        logic [QW-1:0] res;
        logic          hit;
        res = '0;
        hit = 1'b0;
        for (int k = 1; k <= NQ; k++) begin
            int j;
            j = (int'(from) + k) % NQ;
            if (!hit && v[j]) begin
                res = QW'(j);
                hit = 1'b1;
            end
        end
        return res;
    endfunction

    always_comb begin
        stat_req = nonempty & act_static & act_attached;
        for (int r = 0; r < ROUNDS; r++) begin
            for (int q = 0; q < NQ; q++) begin
                elig[r][q] = nonempty[q] && act_attached[q] && !act_static[q]
                             && act_mask[q][r];
            end
        end
        remain = elig[round_q] & ~served_q;

        stat_idx = '0;
        for (int q = NQ - 1; q >= 0; q--) begin
            if (stat_req[q]) stat_idx = QW'(q);
        end

        // Nearest later round with work; k = ROUNDS revisits the current round.
        nr_found = 1'b0;
        nr_round = round_q;
        rr       = round_q;
        for (int k = ROUNDS; k >= 1; k--) begin
            rr = round_q + ROUND_W'(k);
            if (|elig[rr]) begin
                nr_found = 1'b1;
                nr_round = rr;
            end
        end
    end

    // Decision
    always_comb begin
        kind      = PICK_NONE;
        gnt_idx   = '0;
        round_sel = round_q;
        if (|stat_req) begin
            kind    = PICK_STATIC;
            gnt_idx = stat_idx;
        end else if (|remain) begin
            kind    = PICK_SAME;
            gnt_idx = first_after(remain, last_q);
        end else if (nr_found) begin
            kind      = PICK_NEXT;
            gnt_idx   = first_after(elig[nr_round], last_q);
            round_sel = nr_round;
        end
        gnt_vld = take && (kind != PICK_NONE);
    end

    // Round state
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            round_q  <= '0;
            served_q <= '0;
            last_q   <= QW'(NQ - 1);
        end else if (gnt_vld) begin
            unique case (kind)
                PICK_SAME: begin
                    served_q[gnt_idx] <= 1'b1;
                    last_q            <= gnt_idx;
                end
                PICK_NEXT: begin
                    round_q  <= nr_round;
                    served_q <= '0;
                    served_q[gnt_idx] <= 1'b1;
                    last_q   <= gnt_idx;
                end
                PICK_STATIC, PICK_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = $clog2(NQ),
    parameter int CW = $clog2(NQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [QW-1:0]      cfg_qsel,
    input  logic [CODE_W-1:0]  cfg_code,
    input  logic               cfg_commit,
    input  logic [CW-1:0]      cfg_count,
    output logic               cfg_err,
    input  logic [NQ-1:0]      q_nonempty,
    input  logic               out_ready,
    output logic               gnt_vld,
    output logic [NQ-1:0]      gnt_oh,
    output logic [QW-1:0]      gnt_idx,
    output logic               gnt_static,
    output logic               gnt_tail,
    output logic [ROUND_W-1:0] gnt_round
);

    logic [NQ-1:0][ROUNDS-1:0] act_mask;
    logic [NQ-1:0]             act_static;
    logic [NQ-1:0]             act_attached;
    logic [CW-1:0]             act_cnt;
    logic                      apply;
    pick_e                     kind;

    wrr_cfg_table #(.NQ(NQ), .QW(QW), .CW(CW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_idx       (cfg_qsel),
        .wr_code      (cfg_code),
        .commit       (cfg_commit),
        .commit_cnt   (cfg_count),
        .act_mask     (act_mask),
        .act_static   (act_static),
        .act_attached (act_attached),
        .act_cnt      (act_cnt),
        .cfg_err      (cfg_err),
        .apply        (apply)
    );

    wrr_round_pick #(.NQ(NQ), .QW(QW)) u_pick (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (apply),
        .take         (out_ready),
        .nonempty     (q_nonempty),
        .act_mask     (act_mask),
        .act_static   (act_static),
        .act_attached (act_attached),
        .gnt_vld      (gnt_vld),
        .gnt_idx      (gnt_idx),
        .round_sel    (gnt_round),
        .kind         (kind)
    );

    // Grant decoration
    always_comb begin
        gnt_oh     = '0;
        gnt_static = 1'b0;
        gnt_tail   = 1'b0;
        if (gnt_vld) begin
            gnt_oh[gnt_idx] = 1'b1;
            gnt_static      = (kind == PICK_STATIC);
            gnt_tail        = ((CW'(gnt_idx) + CW'(1)) == act_cnt);
        end
    end

endmodule

// File: rtl/wrr_sched_chk.sv
module wrr_sched_chk
    import wrr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int QW = $clog2(NQ)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      out_ready,
    input logic [NQ-1:0]             q_nonempty,
    input logic                      gnt_vld,
    input logic [NQ-1:0]             gnt_oh,
    input logic [QW-1:0]             gnt_idx,
    input logic                      gnt_static,
    input logic                      cfg_err,
    input logic [NQ-1:0][ROUNDS-1:0] act_mask,
    input logic [NQ-1:0]             act_static,
    input logic [NQ-1:0]             act_attached
);

    logic [NQ-1:0] live;
    always_comb begin
        for (int q = 0; q < NQ; q++) live[q] = |act_mask[q];
    end

    AST_READY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !gnt_vld); // R6

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ($countones(gnt_oh) == 1) && gnt_oh[gnt_idx]); // R7

    AST_GNT_ATTACHED: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> q_nonempty[gnt_idx] && act_attached[gnt_idx]); // R10

    AST_STATIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && |(q_nonempty & act_static & act_attached)) |-> gnt_static); // R3

    AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && |(q_nonempty & act_attached & ~act_static & live)) |-> gnt_vld); // R5

    AST_ERR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $stable(act_attached) && $stable(act_static)); // R8

endmodule

bind wrr_sched wrr_sched_chk #(.NQ(NQ), .QW(QW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_ready    (out_ready),
    .q_nonempty   (q_nonempty),
    .gnt_vld      (gnt_vld),
    .gnt_oh       (gnt_oh),
    .gnt_idx      (gnt_idx),
    .gnt_static   (gnt_static),
    .cfg_err      (cfg_err),
    .act_mask     (act_mask),
    .act_static   (act_static),
    .act_attached (act_attached)
);

// File: tb/wrr_sched_tb_top.sv
`timescale 1ns/1ps
module wrr_sched_tb_top;

    localparam int NQ = 8;
    localparam int QW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [QW-1:0] cfg_qsel;
    logic [3:0]    cfg_code;
    logic          cfg_commit;
    logic [CW-1:0] cfg_count;
    logic          cfg_err;
    logic [NQ-1:0] q_nonempty;
    logic          out_ready;
    logic          gnt_vld;
    logic [NQ-1:0] gnt_oh;
    logic [QW-1:0] gnt_idx;
    logic          gnt_static;
    logic          gnt_tail;
    logic [2:0]    gnt_round;

    always #2 clk = ~clk;

    wrr_sched #(.NQ(NQ)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_qsel   (cfg_qsel),
        .cfg_code   (cfg_code),
        .cfg_commit (cfg_commit),
        .cfg_count  (cfg_count),
        .cfg_err    (cfg_err),
        .q_nonempty (q_nonempty),
        .out_ready  (out_ready),
        .gnt_vld    (gnt_vld),
        .gnt_oh     (gnt_oh),
        .gnt_idx    (gnt_idx),
        .gnt_static (gnt_static),
        .gnt_tail   (gnt_tail),
        .gnt_round  (gnt_round)
    );

    int checks = 0;
    int errors = 0;
    int a_code [NQ];
    int s_code [NQ];
    int a_cnt;
    int m_round;
    int m_last;
    logic [NQ-1:0] m_served;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2 mapping
    function automatic logic [7:0] ref_mask(input int c);
        case (c)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h11;
            3: return 8'h49;
            4: return 8'h55;
            5: return 8'h57;
            6: return 8'h77;
            7: return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit ref_elig(input int r, input int q, input logic [NQ-1:0] ne);
        logic [7:0] m;
        m = ref_mask(a_code[q]);
        return (q < a_cnt) && ne[q] && (a_code[q] != 9) && m[r];
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    // One cycle: drive, predict, compare, advance the reference state.
    task automatic cycle(input logic [NQ-1:0] ne, input logic rdy);
        int kind;
        int ei;
        int er;
        string req;
        @(negedge clk);
        q_nonempty = ne;
        out_ready  = rdy;
        #1;
        kind = 0; ei = 0; er = m_round;
        for (int q = NQ - 1; q >= 0; q--)
            if (q < a_cnt && ne[q] && a_code[q] == 9) begin kind = 1; ei = q; end
        if (kind == 0)
            for (int k = 1; k <= NQ; k++) begin
                int j;
                j = (m_last + k) % NQ;
                if (kind == 0 && ref_elig(m_round, j, ne) && !m_served[j]) begin
                    kind = 2; ei = j;
                end
            end
        if (kind == 0)
            for (int d = 1; d <= 8; d++) begin
                int r;
                r = (m_round + d) % 8;
                for (int k = 1; k <= NQ; k++) begin
                    int j;
                    j = (m_last + k) % NQ;
                    if (kind == 0 && ref_elig(r, j, ne)) begin
                        kind = 3; ei = j; er = r;
                    end
                end
            end
        if (!rdy) kind = 0;
        case (kind)
            1: req = "R3";
            2: req = "R4";
            3: req = "R5";
            default: req = rdy ? "R5" : "R6";
        endcase
        check(gnt_vld == (kind != 0), req, "gnt_vld", int'(gnt_vld), int'(kind != 0));
        check(gnt_oh == ((kind != 0) ? NQ'(1) << ei : '0), "R7", "gnt_oh",
              int'(gnt_oh), (kind != 0) ? (1 << ei) : 0);
        if (kind != 0 && gnt_vld) begin
            check(int'(gnt_idx) == ei, req, "gnt_idx", int'(gnt_idx), ei);
            check(gnt_static == (kind == 1), "R3", "gnt_static", int'(gnt_static), int'(kind == 1));
            check(gnt_tail == (ei == a_cnt - 1), "R7", "gnt_tail", int'(gnt_tail), int'(ei == a_cnt - 1));
            check(int'(gnt_round) == er, req, "gnt_round", int'(gnt_round), er);
        end
        if (kind == 2) begin
            m_served[ei] = 1'b1; m_last = ei;
        end else if (kind == 3) begin
            m_round = er; m_served = '0; m_served[ei] = 1'b1; m_last = ei;
        end
    endtask

    task automatic write_code(input int q, input int c);
        @(negedge clk);
        out_ready = 1'b0;
        cfg_we    = 1'b1;
        cfg_qsel  = QW'(q);
        cfg_code  = 4'(c);
        @(negedge clk);
        cfg_we    = 1'b0;
        s_code[q] = c;
    endtask

    // R8 / R9 / R10: commit, wait two edges, compare error flag with own validity rule.
    task automatic commit(input int cnt);
        bit ok;
        bit seen_weighted;
        @(negedge clk);
        out_ready  = 1'b0;
        cfg_commit = 1'b1;
        cfg_count  = CW'(cnt);
        @(negedge clk);
        cfg_commit = 1'b0;
        @(negedge clk);
        #1;
        ok = (cnt >= 1) && (cnt <= NQ);
        seen_weighted = 1'b0;
        for (int q = 0; q < NQ; q++) begin
            if (q < cnt) begin
                if (s_code[q] > 9) ok = 1'b0;
                if (s_code[q] == 9 && seen_weighted) ok = 1'b0;
                if (s_code[q] != 9) seen_weighted = 1'b1;
            end
        end
        check(cfg_err == !ok, "R8", "cfg_err", int'(cfg_err), int'(!ok));
        if (ok) begin
            for (int q = 0; q < NQ; q++) a_code[q] = s_code[q];
            a_cnt    = cnt;
            m_round  = 0;
            m_served = '0;
            m_last   = NQ - 1;
        end
    endtask

    task automatic run_random(input int n, input int mode);
        logic [NQ-1:0] ne;
        for (int i = 0; i < n; i++) begin
            lfsr = lfsr_next(lfsr);
            case (mode)
                0: ne = lfsr[7:0] | lfsr[15:8];
                1: ne = lfsr[7:0] & lfsr[15:8];
                default: ne = lfsr[7:0];
            endcase
            cycle(ne, lfsr[3] | lfsr[9]);
        end
    endtask

    initial begin
        int cnt0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_qsel = '0; cfg_code = '0;
        cfg_commit = 1'b0; cfg_count = '0; q_nonempty = '0; out_ready = 1'b0;
        for (int q = 0; q < NQ; q++) begin a_code[q] = 0; s_code[q] = 0; end
        a_cnt = 0; m_round = 0; m_served = '0; m_last = NQ - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing attached after reset
        #1;
        check(cfg_err == 1'b0, "R1", "cfg_err after reset", int'(cfg_err), 0);
        for (int i = 0; i < 4; i++) cycle('1, 1'b1);
        check(gnt_vld == 1'b0, "R1", "gnt_vld after reset", int'(gnt_vld), 0);

        // R2: weight sweep against a full-weight partner, all queues full
        for (int w = 0; w <= 8; w++) begin
            write_code(0, w);
            write_code(1, 8);
            commit(2);
            cnt0 = 0;
            for (int i = 0; i < 8 + w; i++) begin
                cycle('1, 1'b1);
                if (gnt_vld && gnt_idx == 0) cnt0++;
            end
            check(cnt0 == w, "R2", "grants of weighted queue per round cycle", cnt0, w);
            // R6: stalled downstream
            for (int i = 0; i < 3; i++) cycle('1, 1'b0);
            for (int i = 0; i < 5; i++) cycle('1, 1'b1);
        end

        // R3/R4/R5: strict prefix sweep under random traffic
        for (int s = 0; s <= 3; s++) begin
            for (int q = 0; q < NQ; q++)
                write_code(q, (q < s) ? 9 : ((q * 3 + s) % 9));
            commit(8);
            run_random(150, 0);
            run_random(150, 1);
            run_random(100, 2);
        end

        // R9: recommit mid-round restarts the scheduler
        run_random(7, 0);
        commit(8);
        for (int i = 0; i < 12; i++) cycle('1, 1'b1);

        // R8: non-contiguous strict run rejected, old table still used
        for (int q = 0; q < NQ; q++) write_code(q, (q == 0) ? 9 : q);
        commit(5);
        write_code(3, 9);
        commit(5);
        run_random(120, 0);
        // R8: strict run not starting at queue 0
        write_code(3, 4);
        write_code(0, 6);
        write_code(1, 9);
        commit(5);
        run_random(60, 0);
        // R8: out-of-range code on an attached queue
        write_code(1, 13);
        commit(5);
        run_random(60, 1);
        // R8: zero attached queues
        write_code(1, 2);
        commit(0);
        run_random(40, 0);
        // R10: bad code in an unattached slot is ignored
        write_code(6, 14);
        commit(5);
        run_random(120, 0);
        check(cfg_err == 1'b0, "R10", "cfg_err with bad unattached code", int'(cfg_err), 0);

        // R5: sparse traffic forces round skipping
        for (int q = 0; q < NQ; q++) write_code(q, (q % 2 == 0) ? 1 : 3);
        commit(8);
        run_random(300, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R6 watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule